// File: doc/BRIEF.md
# Filtered Edge Timestamp Channel

This block records when an edge arrives on an asynchronous input, measured against a free-running counter that runs on the bus clock. The raw input first passes through a two-stage synchronizer. It is then examined only on every fourth bus clock, and a programmable digital filter must accept it before any edge counts. When the filter accepts a level change whose direction matches the selected edge, the block copies the counter into a capture register and sets a sticky flag that drives an interrupt request.

Software reads the capture value and clears the flag with a one-cycle pulse. If a second accepted edge arrives before that clear, the capture register is overwritten and an overflow indicator is set. The time from the input edge to the flag depends only on the filter setting and on where the edge falls relative to the sample phase. Firmware can therefore subtract a known constant from the captured count to recover the edge time.

Top module: `edge_timestamp`

## Requirements
- R1: While reset is low, and in the first cycle after it, cap_val, cap_flag, cap_ovf and irq are all 0. The free-running counter starts at 0 on reset release and adds one on every clock, wrapping at its width.
- R2: The input is examined only in cycles whose counter value is 3 modulo 4. As a result, every flag first reads high in a cycle whose counter value is 1 modulo 4.
- R3: Let an input change be applied during the cycle in which the counter reads k, with filter value N. The flag first reads high in the cycle in which the counter reads k + 4 + 4·N + p, where p = (1 − k) mod 4. When p = 0 the delay is exactly 4 + 4·N clocks.
- R4: With edge_fall = 0 only a low-to-high accepted change sets the flag. With edge_fall = 1 only a high-to-low change sets it. A change in the other direction leaves the flag at 0.
- R5: For N ≥ 1, a pulse that lasts 4·N clocks is discarded and sets no flag. A pulse that lasts 4·N + 4 clocks is accepted.
- R6: On a capture, cap_val takes the counter value from the clock edge that sets the flag. This is one less than the counter value in the first cycle in which the flag reads high.
- R7: Once set, the flag stays high until flag_clr is high at a clock edge. That edge clears both the flag and the overflow indicator.
- R8: A capture that arrives while the flag is high, with no clear on that edge, overwrites cap_val and sets cap_ovf.
- R9: When a clear and a capture fall on the same edge, the flag stays high, cap_ovf is 0 and cap_val holds the new count.
- R10: irq is high exactly when the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous input |
| edge_fall | input | 1 | 0 selects rising edges, 1 selects falling edges |
| filt_n | input | 4 | Filter value N |
| flag_clr | input | 1 | One-cycle request to clear the flag and the overflow indicator |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_ovf | output | 1 | Set when a capture overwrote an unread one |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 16-bit counter and the fixed divide-by-four sample rate. This keeps every run within a short window, so all 16 filter values, both edge polarities and all four phases of the input change against the sample tick are swept exhaustively. The expected delay and captured count for each case are derived from the counter value at the moment of the change. A per-filter-value pulse-width sweep covers the discard boundary, and scheduled clears reach the same-edge clear and capture case.

// File: rtl/ts_pkg.sv
package ts_pkg;

  localparam int FILT_W = 4;

  typedef struct packed {
    logic              lvl;
    logic [FILT_W-1:0] run;
  } filt_state_t;

  // One filter step at a sample tick: a differing sample must be seen
  // N+1 times in a row before the accepted level follows it.
  function automatic filt_state_t filt_step(filt_state_t s, logic smp,
                                            logic [FILT_W-1:0] n);
    filt_state_t r;
    r = s;
    if (smp == s.lvl) begin
      r.run = '0;
    end else if (s.run == n) begin
      r.lvl = smp;
      r.run = '0;
    end else begin
      r.run = s.run + 1'b1;
    end
    return r;
  endfunction

  // Shortest delay from input change to flag, in bus clocks.
  function automatic int unsigned min_delay(int unsigned n);
    return 4 + 4 * n;
  endfunction

endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ts_sample_div.sv
module ts_sample_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int QW = $clog2(DIV);
      localparam logic [QW-1:0] LAST = QW'(DIV - 1);
      logic [QW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/ts_filter.sv
module ts_filter
  import ts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              smp,
  input  logic [FILT_W-1:0] n,
  output logic              lvl,
  output logic              accept
);
  filt_state_t st, nx;

  always_comb nx = filt_step(st, smp, n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    st <= '0;
    else if (tick) st <= nx;

  assign lvl    = st.lvl;
  assign accept = tick && (nx.lvl != st.lvl);
endmodule

// File: rtl/edge_timestamp.sv
module edge_timestamp
  import ts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              edge_fall,
  input  logic [FILT_W-1:0] filt_n,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  cap_val,
  output logic              cap_flag,
  output logic              cap_ovf,
  output logic              irq
);
  localparam int SYNC_STAGES = 2;
  localparam int SAMPLE_DIV  = 4;

  // Named internal events, brought out for the checker.
  logic             smp;
  logic             tick;
  logic             lvl;
  logic             accept;
  logic             evt_raw;
  logic             cap_evt;
  logic [CNT_W-1:0] free_cnt;

  ts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
  );

  ts_sample_div #(.DIV(SAMPLE_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ts_filter u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .smp(smp), .n(filt_n),
    .lvl(lvl), .accept(accept)
  );

  // Old level low means the accepted change is rising.
  assign evt_raw = accept && (lvl == edge_fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_evt <= 1'b0;
    else        cap_evt <= evt_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) free_cnt <= '0;
    else        free_cnt <= free_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      cap_ovf  <= 1'b0;
    end else if (cap_evt) begin
      cap_val  <= free_cnt;
      cap_flag <= 1'b1;
      cap_ovf  <= cap_flag && !flag_clr;
    end else if (flag_clr) begin
      cap_flag <= 1'b0;
      cap_ovf  <= 1'b0;
    end
  end

  assign irq = cap_flag;
endmodule

// File: rtl/edge_timestamp_chk.sv
module edge_timestamp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flag_clr,
  input logic             tick,
  input logic             accept,
  input logic             cap_evt,
  input logic [CNT_W-1:0] free_cnt,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             cap_ovf
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> free_cnt == CNT_W'($past(free_cnt) + 1'b1));

  a_r2_accept_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> tick);

  a_r6_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag && cap_val == $past(free_cnt));

  a_r6_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !flag_clr |=> cap_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !cap_evt |=> !cap_flag && !cap_ovf);

  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && cap_flag && !flag_clr |=> cap_ovf);

  a_r9_clear_vs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && flag_clr |=> cap_flag && !cap_ovf);
endmodule

bind edge_timestamp edge_timestamp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .tick(tick),
  .accept(accept), .cap_evt(cap_evt), .free_cnt(free_cnt),
  .cap_val(cap_val), .cap_flag(cap_flag), .cap_ovf(cap_ovf)
);

// File: tb/edge_timestamp_test.sv
module edge_timestamp_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin = 1'b0;
  logic          efall = 1'b0;
  logic          clr = 1'b0;
  logic [3:0]    fn = 4'd0;
  wire  [CW-1:0] capv;
  wire           flg, ovf, irq;

  edge_timestamp #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .edge_fall(efall),
    .filt_n(fn), .flag_clr(clr), .cap_val(capv), .cap_flag(flg),
    .cap_ovf(ovf), .irq(irq)
  );

  always #4 clk = ~clk;

  // Reference time base: reads 0 on reset release, +1 per clock.
  logic [CW-1:0] tcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic do_clear();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic wait_flag(int lim, output bit got, output logic [CW-1:0] fc);
    got = 0; fc = '0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (flg) begin got = 1; fc = tcnt; end
    end
    step();
  endtask

  function automatic int phase_lag(logic [CW-1:0] k);
    return (5 - int'(k[1:0])) % 4;
  endfunction

  task automatic run_case(bit pol, int n, int ph);
    bit got;
    logic [CW-1:0] k, fc, lat;
    int expd;
    efall = pol; fn = 4'(n);
    if (pin != pol) begin
      pin = pol; idle(4*n + 12);
      chk(flg == 1'b0, "R4 opposite edge ignored", flg, 0);
    end
    while (int'(tcnt[1:0]) != ph) step();
    k = tcnt; pin = ~pol;
    expd = 4 + 4*n + phase_lag(k);
    wait_flag(4*n + 20, got, fc);
    chk(got, "R4 selected edge flags", got, 1);
    lat = fc - k;
    chk(int'(lat) == expd, "R3 delay", lat, expd);
    chk(fc[1:0] == 2'd1, "R2 flag phase", fc[1:0], 1);
    chk(capv == fc - 1'b1, "R6 capture value", capv, fc - 1'b1);
    chk(irq == 1'b1, "R10 irq with flag", irq, 1);
    do_clear();
    chk(flg == 1'b0 && ovf == 1'b0, "R7 clear", flg, 0);
    chk(irq == 1'b0, "R10 irq low", irq, 0);
  endtask

  initial begin
    bit got;
    logic [CW-1:0] k, fc, expc, f;
    idle(3);
    chk(capv == '0 && flg == 0 && ovf == 0 && irq == 0, "R1 reset outputs", capv, 0);
    rst_n = 1'b1;
    #1;
    chk(flg == 0 && ovf == 0 && irq == 0 && capv == '0, "R1 after release", flg, 0);
    idle(2);

    for (int pol = 0; pol < 2; pol++)
      for (int n = 0; n < 16; n++)
        for (int ph = 0; ph < 4; ph++)
          run_case(pol[0], n, ph);

    // R5: discard boundary per filter value (rising select, idle low)
    efall = 1'b0;
    if (pin) begin pin = 1'b0; fn = 4'd0; idle(12); end
    for (int n = 1; n < 16; n++) begin
      fn = 4'(n);
      pin = 1'b1; idle(4*n); pin = 1'b0; idle(4*n + 12);
      chk(flg == 1'b0, "R5 short pulse discarded", flg, 0);
      pin = 1'b1; idle(4*n + 4); pin = 1'b0; idle(4*n + 12);
      chk(flg == 1'b1, "R5 long pulse accepted", flg, 1);
      do_clear();
    end

    // R8: second capture before clear
    fn = 4'd0;
    pin = 1'b1; idle(12);
    chk(flg == 1'b1 && ovf == 1'b0, "R8 first capture", ovf, 0);
    pin = 1'b0; idle(12);
    k = tcnt; pin = 1'b1;
    expc = k + 16'(3 + phase_lag(k));
    idle(12);
    chk(flg == 1'b1 && ovf == 1'b1, "R8 overflow set", ovf, 1);
    chk(capv == expc, "R8 capture overwritten", capv, expc);
    do_clear();
    chk(ovf == 1'b0 && flg == 1'b0, "R7 clear drops overflow", ovf, 0);

    // R9: clear on the same edge as a capture
    pin = 1'b0; idle(12);
    pin = 1'b1; idle(12);
    pin = 1'b0; idle(12);
    chk(flg == 1'b1, "R9 flag set before", flg, 1);
    k = tcnt; pin = 1'b1;
    f = k + 16'(3 + phase_lag(k));
    while (tcnt != f) step();
    clr = 1'b1; step(); clr = 1'b0;
    chk(flg == 1'b1, "R9 flag kept", flg, 1);
    chk(ovf == 1'b0, "R9 no overflow", ovf, 0);
    chk(capv == f, "R9 new capture", capv, f);
    do_clear();
    chk(flg == 1'b0, "R7 final clear", flg, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule